// File: doc/BRIEF.md
# USB Endpoint-Zero Control Stage Engine

This block is the device-side hardware that follows a USB control transfer on endpoint 0 through its stages. A packet-level front end hands it packet boundaries, received bytes and IN tokens. The engine collects the eight-byte setup command into a small buffer. It shows the state of the transfer in an 8-bit control/status register and pulses an endpoint-0 interrupt at each stage boundary. For every packet or token it accepts, it returns a handshake code.

Firmware reads the command bytes through a pop port, decodes them, and then writes the status register. The write either confirms the command and closes the data phase, or it asks for the request to be refused. When the host reaches the status stage, the engine answers with ACK or STALL according to that write. The engine also protects the sequence on its own. A setup packet of the wrong length is dropped without a trace. Data the host sends after the data phase was closed is stalled. A new setup that arrives before the previous request finished raises a setup-end error flag.

Top module: `ep0_ctrl_engine`

## Requirements
- R1: A setup packet with exactly 8 data bytes sets bit 0 (receive-ready) of the status register. It replies with handshake ACK (code 2'b01) and pulses the interrupt once. Its bytes then come out of the pop port in arrival order.
- R2: A setup packet with any other byte count is dropped. It gives no handshake, no interrupt and no change to receive-ready. A previously held command stays readable, unchanged.
- R3: Writing 1 to bit 6 (serviced) clears receive-ready and releases the buffer, so that the pop port returns 0. Bit 6 always reads as 0.
- R4: After bit 3 (data-end) is written 1, a status token completes the request. A status token is an IN token or a zero-length OUT packet. The completion gives ACK, clears data-end and pulses the interrupt.
- R5: If bit 5 (send-stall) is set when a status token arrives, the reply is STALL (code 2'b11). Bit 2 (sent-stall) is set, send-stall is cleared and the interrupt pulses.
- R6: An OUT packet carrying data while data-end is set gets STALL. It sets sent-stall, clears data-end and pulses the interrupt.
- R7: A valid setup arriving while a request is still open sets bit 4 (setup-end). A request is open from its valid setup until it completes or is stalled. A valid setup arriving when no request is open leaves bit 4 clear.
- R8: Sent-stall and setup-end clear only when their bits are written 0. Writing 1 to them leaves them unchanged.
- R9: A valid setup clears any pending data-end and send-stall.
- R10: The interrupt is a one-cycle pulse per event. The pulse also sets the pending output, which a register read strobe clears.
- R11: A status token or a data OUT packet that meets neither data-end nor send-stall gets NAK (code 2'b10). It raises no interrupt.
- R12: Popping past the eighth byte of a held command returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sop | input | 1 | Start of a received packet |
| rx_is_setup | input | 1 | With rx_sop: 1 for a setup packet, 0 for OUT data |
| rx_dv | input | 1 | A received data byte is valid |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | End of the received packet |
| in_tok | input | 1 | Host IN token on endpoint 0 |
| hs_vld | output | 1 | Handshake code valid (one cycle) |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 8 | Status register write data |
| csr_rd | input | 1 | Status register read strobe (clears pending) |
| csr_rdata | output | 8 | Status register read data |
| fifo_rd | input | 1 | Pop one command byte |
| fifo_rdata | output | 8 | Command byte at the pop pointer |
| irq | output | 1 | Endpoint-0 interrupt pulse |
| irq_pend | output | 1 | Sticky interrupt pending flag |

## Verification
On every cycle, the assertions check that an accepted setup raises receive-ready, ACK and the interrupt together. They also check that a rejected setup leaves the handshake and the interrupt silent, that every STALL shows sent-stall set, that NAK never comes with an interrupt, and that each pulse sets the pending flag. Only the bench scenarios show the rest. These are the whole sweep of setup lengths, byte order and a held command surviving a bad packet, the write-0-to-clear rules, setup-end appearing only for an open request, and the pop port reading 0 after release or past the end.

// File: rtl/ep0_pkg.sv
// Shared types for the endpoint-zero engine: handshake codes and
// status register bit positions. Assumes an 8-bit status register.
package ep0_pkg;
    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    localparam int B_RXRDY  = 0;
    localparam int B_SENT   = 2;
    localparam int B_DEND   = 3;
    localparam int B_SETEND = 4;
    localparam int B_SSTALL = 5;
    localparam int B_SERV   = 6;
endpackage

// File: rtl/ep0_setup_buf.sv
// Setup command buffer. Counts the bytes of every packet. It collects
// setup bytes in a staging copy and commits them to the held copy
// only when the count is exactly NBYTES. That keeps a held command
// safe from a malformed packet. Assumes NBYTES is a power of two
// and that sop, dv and eop never coincide.
module ep0_setup_buf #(
    parameter int NBYTES = 8,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sop,
    input  logic          is_setup,
    input  logic          dv,
    input  logic [DW-1:0] din,
    input  logic          eop,
    input  logic          pop,
    input  logic          hold_valid,
    output logic [DW-1:0] dout,
    output logic          setup_ok,
    output logic          setup_bad,
    output logic          out_end,
    output logic          out_zero
);
    localparam int CW = $clog2(NBYTES + 2);
    localparam int IW = $clog2(NBYTES);
    localparam int PW = $clog2(NBYTES + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(NBYTES);
    localparam logic [CW-1:0] CNT_SAT  = CW'(NBYTES + 1);

    logic [CW-1:0] cnt;
    logic          setup_q;
    logic [DW-1:0] stage [NBYTES];
    logic [DW-1:0] held  [NBYTES];
    logic [PW-1:0] rptr;

    // Packet length classification at end of packet
    assign setup_ok  = eop && setup_q && (cnt == CNT_FULL);
    assign setup_bad = eop && setup_q && (cnt != CNT_FULL);
    assign out_end   = eop && !setup_q;
    assign out_zero  = (cnt == '0);

    // Byte counter and packet kind, saturating past the command length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            setup_q <= 1'b0;
        end else if (sop) begin
            cnt     <= '0;
            setup_q <= is_setup;
        end else if (dv && cnt != CNT_SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Staging and held copies of the command bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) begin
                stage[i] <= '0;
                held[i]  <= '0;
            end
        end else begin
            if (dv && setup_q && cnt < CNT_FULL)
                stage[cnt[IW-1:0]] <= din;
            if (setup_ok)
                for (int i = 0; i < NBYTES; i++)
                    held[i] <= stage[i];
        end
    end

    // Pop pointer: rewinds on commit, stops at the end
    always_ff @(posedge clk) begin
        if (!rst_n)
            rptr <= '0;
        else if (setup_ok)
            rptr <= '0;
        else if (pop && rptr < PW'(NBYTES))
            rptr <= rptr + 1'b1;
    end

    // Pop data, zero when released or exhausted
    always_comb begin
        dout = '0;
        if (hold_valid && rptr < PW'(NBYTES))
            dout = held[rptr[IW-1:0]];
    end
endmodule

// File: rtl/ep0_stage_ctl.sv
// Stage controller: holds the status bits, tracks whether a request
// is open, picks the handshake and pulses the interrupt. Packet events
// are applied after firmware writes in the same cycle, so they win.
// Assumes at most one packet event per cycle.
module ep0_stage_ctl
    import ep0_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       setup_ok,
    input  logic       setup_bad,
    input  logic       out_end,
    input  logic       out_zero,
    input  logic       in_tok,
    input  logic       wr,
    input  logic [7:0] wd,
    output logic       rx_ready,
    output logic       data_end,
    output logic       send_stall,
    output logic       sent_stall,
    output logic       setup_end,
    output logic       hs_vld,
    output logic [1:0] hs_code,
    output logic       irq
);
    logic busy;
    logic n_rr, n_de, n_ss, n_sent, n_se, n_busy, n_irq;
    hs_e  n_hs;
    logic status_tok, data_out;

    assign status_tok = in_tok || (out_end && out_zero);
    assign data_out   = out_end && !out_zero;

    // Next state: firmware write first, then the packet event
    always_comb begin
        n_rr = rx_ready; n_de = data_end; n_ss = send_stall;
        n_sent = sent_stall; n_se = setup_end; n_busy = busy;
        n_irq = 1'b0; n_hs = HS_NONE;
        if (wr) begin
            if (wd[B_SERV])    n_rr = 1'b0;
            if (wd[B_DEND])    n_de = 1'b1;
            if (wd[B_SSTALL])  n_ss = 1'b1;
            if (!wd[B_SENT])   n_sent = 1'b0;
            if (!wd[B_SETEND]) n_se = 1'b0;
        end
        if (setup_ok) begin
            n_rr = 1'b1; n_de = 1'b0; n_ss = 1'b0;
            if (busy) n_se = 1'b1;
            n_busy = 1'b1; n_hs = HS_ACK; n_irq = 1'b1;
        end else if (status_tok || data_out) begin
            if (send_stall || (data_out && data_end)) begin
                n_hs = HS_STALL; n_sent = 1'b1; n_ss = 1'b0;
                n_de = 1'b0; n_busy = 1'b0; n_irq = 1'b1;
            end else if (status_tok && data_end) begin
                n_hs = HS_ACK; n_de = 1'b0; n_busy = 1'b0; n_irq = 1'b1;
            end else begin
                n_hs = HS_NAK;
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ready <= 1'b0; data_end <= 1'b0; send_stall <= 1'b0;
            sent_stall <= 1'b0; setup_end <= 1'b0; busy <= 1'b0;
            hs_vld <= 1'b0; hs_code <= HS_NONE; irq <= 1'b0;
        end else begin
            rx_ready <= n_rr; data_end <= n_de; send_stall <= n_ss;
            sent_stall <= n_sent; setup_end <= n_se; busy <= n_busy;
            hs_vld <= (n_hs != HS_NONE); hs_code <= n_hs; irq <= n_irq;
        end
    end

    assert_setup_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ok |=> (rx_ready && irq && hs_vld && hs_code == HS_ACK));

    assert_bad_setup_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_bad && !(wr && wd[B_SERV])) |=> (!irq && !hs_vld && $stable(rx_ready)));

    assert_stall_flags_sent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_vld && hs_code == HS_STALL) |-> sent_stall);

    assert_nak_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_vld && hs_code == HS_NAK) |-> !irq);
endmodule

// File: rtl/ep0_ctrl_engine.sv
// Endpoint-zero control stage engine top. Wires the setup buffer to
// the stage controller, assembles the status register view and keeps
// the sticky interrupt pending flag. Assumes the packet front end has
// already checked CRC and address.
module ep0_ctrl_engine
    import ep0_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_sop,
    input  logic          rx_is_setup,
    input  logic          rx_dv,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_eop,
    input  logic          in_tok,
    output logic          hs_vld,
    output logic [1:0]    hs_code,
    input  logic          csr_wr,
    input  logic [7:0]    csr_wdata,
    input  logic          csr_rd,
    output logic [7:0]    csr_rdata,
    input  logic          fifo_rd,
    output logic [DW-1:0] fifo_rdata,
    output logic          irq,
    output logic          irq_pend
);
    logic setup_ok, setup_bad, out_end, out_zero;
    logic rx_ready, data_end, send_stall, sent_stall, setup_end;

    ep0_setup_buf #(.NBYTES(NBYTES), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .sop(rx_sop), .is_setup(rx_is_setup),
        .dv(rx_dv), .din(rx_byte), .eop(rx_eop), .pop(fifo_rd),
        .hold_valid(rx_ready), .dout(fifo_rdata), .setup_ok(setup_ok),
        .setup_bad(setup_bad), .out_end(out_end), .out_zero(out_zero)
    );

    ep0_stage_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .setup_ok(setup_ok), .setup_bad(setup_bad),
        .out_end(out_end), .out_zero(out_zero), .in_tok(in_tok),
        .wr(csr_wr), .wd(csr_wdata), .rx_ready(rx_ready), .data_end(data_end),
        .send_stall(send_stall), .sent_stall(sent_stall), .setup_end(setup_end),
        .hs_vld(hs_vld), .hs_code(hs_code), .irq(irq)
    );

    // Status register view; serviced bit is write-only
    always_comb begin
        csr_rdata           = '0;
        csr_rdata[B_RXRDY]  = rx_ready;
        csr_rdata[B_SENT]   = sent_stall;
        csr_rdata[B_DEND]   = data_end;
        csr_rdata[B_SETEND] = setup_end;
        csr_rdata[B_SSTALL] = send_stall;
    end

    // Sticky pending flag: set by a pulse, cleared by a register read
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_pend <= 1'b0;
        else if (irq)
            irq_pend <= 1'b1;
        else if (csr_rd)
            irq_pend <= 1'b0;
    end

    assert_pulse_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq_pend);
endmodule

// File: tb/test_ep0_ctrl_engine.sv
`timescale 1ns/1ps
module test_ep0_ctrl_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_sop = 0, rx_is_setup = 0, rx_dv = 0, rx_eop = 0, in_tok = 0;
    logic [7:0] rx_byte = '0;
    logic csr_wr = 0, csr_rd = 0, fifo_rd = 0;
    logic [7:0] csr_wdata = '0;
    logic hs_vld, irq, irq_pend;
    logic [1:0] hs_code;
    logic [7:0] csr_rdata, fifo_rdata;

    int checks = 0, fails = 0;
    int hs_cnt = 0, irq_cnt = 0, run = 0, max_run = 0;
    logic [1:0] last_hs = 2'b00;
    bit done = 0;

    localparam logic [1:0] ACK = 2'b01, NAK = 2'b10, STALL = 2'b11;

    always #2 clk = ~clk;

    ep0_ctrl_engine i_ep0_ctrl_engine (
        .clk(clk), .rst_n(rst_n), .rx_sop(rx_sop), .rx_is_setup(rx_is_setup),
        .rx_dv(rx_dv), .rx_byte(rx_byte), .rx_eop(rx_eop), .in_tok(in_tok),
        .hs_vld(hs_vld), .hs_code(hs_code), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
        .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata), .irq(irq), .irq_pend(irq_pend)
    );

    // Output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (hs_vld) begin hs_cnt++; last_hs = hs_code; end
        if (irq) begin irq_cnt++; run++; if (run > max_run) max_run = run; end
        else run = 0;
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int base, int i);
        return 8'(base + i * 3 + 1);
    endfunction

    task automatic pkt(bit setup, int len, int base);
        @(negedge clk); rx_sop = 1; rx_is_setup = setup;
        @(negedge clk); rx_sop = 0;
        for (int i = 0; i < len; i++) begin
            rx_dv = 1; rx_byte = pat(base, i); @(negedge clk);
        end
        rx_dv = 0; rx_eop = 1;
        @(negedge clk); rx_eop = 0;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk); csr_wr = 1; csr_wdata = d;
        @(negedge clk); csr_wr = 0;
        @(negedge clk);
    endtask

    task automatic tok();
        @(negedge clk); in_tok = 1;
        @(negedge clk); in_tok = 0;
        @(negedge clk);
    endtask

    task automatic pop(output logic [7:0] b);
        @(negedge clk); b = fifo_rdata; fifo_rd = 1;
        @(negedge clk); fifo_rd = 0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int h, q;
        logic [7:0] b;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10", "reset csr", csr_rdata, 0);
        chk("R10", "reset pend", irq_pend, 0);

        // R2: sweep of wrong setup lengths
        for (int len = 0; len <= 12; len++) begin
            if (len == 8) continue;
            h = hs_cnt; q = irq_cnt;
            pkt(1, len, len * 16);
            chk("R2", $sformatf("len %0d hs", len), hs_cnt - h, 0);
            chk("R2", $sformatf("len %0d irq", len), irq_cnt - q, 0);
            chk("R2", $sformatf("len %0d rxrdy", len), csr_rdata[0], 0);
        end

        // R1: valid setup
        h = hs_cnt; q = irq_cnt;
        pkt(1, 8, 8 * 16);
        chk("R1", "ack", (hs_cnt - h == 1 && last_hs == ACK), 1);
        chk("R1", "irq", irq_cnt - q, 1);
        chk("R1", "csr", csr_rdata, 8'h01);
        for (int i = 0; i < 4; i++) begin
            pop(b); chk("R1", $sformatf("byte %0d", i), b, pat(128, i));
        end
        // R2: bad setup while held leaves command intact
        h = hs_cnt;
        pkt(1, 5, 200);
        chk("R2", "held hs", hs_cnt - h, 0);
        chk("R2", "held rxrdy", csr_rdata[0], 1);
        for (int i = 4; i < 8; i++) begin
            pop(b); chk("R2", $sformatf("byte %0d", i), b, pat(128, i));
        end
        pop(b); chk("R12", "past end", b, 0);

        // R3 + R4: serviced with data-end, then IN status
        wr(8'h48);
        chk("R3", "csr after serviced", csr_rdata, 8'h08);
        pop(b); chk("R3", "released buf", b, 0);
        h = hs_cnt; q = irq_cnt;
        tok();
        chk("R4", "status ack", (hs_cnt - h == 1 && last_hs == ACK), 1);
        chk("R4", "status irq", irq_cnt - q, 1);
        chk("R4", "csr", csr_rdata, 0);

        // R10: pending flag and pulse width
        chk("R10", "pend set", irq_pend, 1);
        @(negedge clk); csr_rd = 1; @(negedge clk); csr_rd = 0; @(negedge clk);
        chk("R10", "pend cleared", irq_pend, 0);
        chk("R10", "pulse width", max_run, 1);

        // R5: send-stall at zero-length OUT status
        pkt(1, 8, 40);
        chk("R7", "no setup-end when idle", csr_rdata, 8'h01);
        wr(8'h60);
        chk("R5", "csr send-stall", csr_rdata, 8'h20);
        h = hs_cnt; q = irq_cnt;
        pkt(0, 0, 0);
        chk("R5", "stall", (hs_cnt - h == 1 && last_hs == STALL), 1);
        chk("R5", "irq", irq_cnt - q, 1);
        chk("R5", "csr", csr_rdata, 8'h04);

        // R8: write-1 leaves sent-stall, write-0 clears
        wr(8'h14);
        chk("R8", "write one", csr_rdata, 8'h04);
        wr(8'h00);
        chk("R8", "write zero", csr_rdata, 8'h00);

        // R6: data after data-end
        pkt(1, 8, 60);
        wr(8'h48);
        h = hs_cnt; q = irq_cnt;
        pkt(0, 3, 7);
        chk("R6", "stall", (hs_cnt - h == 1 && last_hs == STALL), 1);
        chk("R6", "irq", irq_cnt - q, 1);
        chk("R6", "csr", csr_rdata, 8'h04);
        wr(8'h00);

        // R11: NAK with neither flag
        pkt(1, 8, 90);
        wr(8'h40);
        h = hs_cnt; q = irq_cnt;
        tok();
        chk("R11", "in nak", (hs_cnt - h == 1 && last_hs == NAK), 1);
        pkt(0, 2, 3);
        chk("R11", "out nak", (hs_cnt - h == 2 && last_hs == NAK), 1);
        chk("R11", "no irq", irq_cnt - q, 0);

        // R7 + R9: new setup while open
        wr(8'h08);
        wr(8'h20);
        chk("R9", "flags before", csr_rdata, 8'h28);
        pkt(1, 8, 110);
        chk("R7", "setup-end", csr_rdata, 8'h11);
        pop(b); chk("R9", "new cmd byte", b, pat(110, 0));
        wr(8'h00);
        chk("R8", "setup-end cleared", csr_rdata, 8'h01);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule